// File: doc/BRIEF.md
# Predicated Element Issue Sequencer

This block expands one scalar three-register operation into a stream of per-element scalar operations. When the block is idle and `start` is high, it takes a vector length, a predicate word and a masking mode. Each of the three register numbers (destination, first source, second source) is looked up in a 32-entry redirection table. An entry marked as a vector swaps in its own start register, and that operand then steps by one register for each element. An operand not marked as a vector keeps its original number, so every element reuses it.

The results leave on a valid/ready stream, one register triple per element plus a flag that asks for zero to be written. Back-pressure rules: the tuple is offered with `iss_valid` high. A transfer happens on any clock edge where `iss_valid` and `iss_ready` are both high. While `iss_ready` is low the tuple stays unchanged and `iss_valid` stays high. The block does not advance until the transfer completes. Skipped elements cost no cycles, because the next element to issue is found directly from the remaining mask. A one-cycle `done` pulse closes each accepted operation.

Top module: `pred_elem_seq`

## Requirements
- R1: After reset, `busy`, `done` and `iss_valid` are all low, and every table entry reads as not-vector.
- R2: Elements are issued in strictly ascending element index, and only elements with index below the effective vector length are issued.
- R3: In skip mode (`zero_mode`=0), element i is issued only when bit i of `pred` is 1. Such elements carry `iss_zero`=0.
- R4: In zero mode (`zero_mode`=1), every element below the vector length is issued. `iss_zero` is 1 exactly when bit i of `pred` is 0.
- R5: For an operand whose table entry has the vector bit set, the issued register is (entry start register + i) mod 32. Otherwise the issued register is the original operand number for every element.
- R6: A write with `tbl_we`=1 stores `tbl_isvec`/`tbl_base` into entry `tbl_addr` at the clock edge. Lookups are taken when the operation is accepted, so writes made during a running operation do not change that operation's stream.
- R7: While `iss_valid` is 1 and `iss_ready` is 0, the next cycle keeps `iss_valid` at 1 and `iss_rd`, `iss_rs1`, `iss_rs2` and `iss_zero` unchanged.
- R8: `done` is high for exactly the one cycle after the final transfer, and `busy` is low in that cycle.
- R9: When nothing would be issued (vector length 0, or an all-zero predicate in skip mode), no transfer is offered, and `done` is high in the cycle after `start` is accepted.
- R10: `start` while `busy` is high is ignored: the stream of the running operation is unchanged and no extra operation follows.
- R11: A `vl` greater than XLEN (32) is treated as XLEN, so at most 32 elements are issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Redirection table write enable |
| tbl_addr | input | 5 | Table entry being written |
| tbl_isvec | input | 1 | Vector flag to write |
| tbl_base | input | 5 | Start register to write |
| start | input | 1 | Begin an operation (taken only when idle) |
| vl | input | 6 | Vector length, clamped to 32 |
| pred | input | 32 | Predicate word, bit i enables element i |
| zero_mode | input | 1 | 1: masked elements issue with zero flag; 0: skipped |
| op_rd | input | 5 | Destination register number |
| op_rs1 | input | 5 | First source register number |
| op_rs2 | input | 5 | Second source register number |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| iss_valid | output | 1 | Issue tuple offered |
| iss_ready | input | 1 | Consumer accepts the tuple |
| iss_rd | output | 5 | Issued destination register |
| iss_rs1 | output | 5 | Issued first source register |
| iss_rs2 | output | 5 | Issued second source register |
| iss_zero | output | 1 | Write zero to the destination element |

## Verification
The hardest cases to reach are a table write and a second `start` that both land while an operation is still issuing. Both must leave the running stream untouched. To create that window, the stimulus holds `iss_ready` low so the operation stays busy for several cycles. It then rewrites an entry the operation uses and pulses `start` with different operands. Only after that does it release `ready`, and it checks the stream against the table contents from before the write. Further runs use a pseudo-random `ready` to cover stall-and-hold behaviour, a redirected start register that wraps past 31, and a vector length above 32.

// File: rtl/pes_pkg.sv
package pes_pkg;
  localparam int unsigned REGW = 5;
  localparam int unsigned NOPS = 3;

  typedef struct packed {
    logic            isvec;
    logic [REGW-1:0] base;
  } remap_ent_t;

  typedef struct packed {
    logic [REGW-1:0] rd;
    logic [REGW-1:0] rs1;
    logic [REGW-1:0] rs2;
    logic            zero;
  } issue_t;
endpackage

// File: rtl/pes_remap_table.sv
module pes_remap_table
  import pes_pkg::*;
#(
  parameter int unsigned NENT = 1 << REGW
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [REGW-1:0]             waddr,
  input  remap_ent_t                  wdata,
  input  logic [NOPS-1:0][REGW-1:0]   raddr,
  output remap_ent_t [NOPS-1:0]       rdata
);
  remap_ent_t tbl_q [NENT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < NENT; e++) tbl_q[e] <= '0;
    end else if (we) begin
      tbl_q[waddr] <= wdata;
    end
  end

  for (genvar k = 0; k < NOPS; k++) begin : g_rd
    assign rdata[k] = tbl_q[raddr[k]];
  end

  // R6
  tbl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> tbl_q[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/pes_first_set.sv
module pes_first_set #(
  parameter int unsigned W    = 32,
  localparam int unsigned IDXW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]    vec,
  output logic [W-1:0]    onehot,
  output logic [IDXW-1:0] idx,
  output logic            any
);
  assign onehot = vec & (~vec + W'(1));
  assign any    = |vec;

  always_comb begin
    idx = '0;
    for (int j = W - 1; j >= 0; j--) begin
      if (vec[j]) idx = IDXW'(j);
    end
  end
endmodule

// File: rtl/pes_seq_ctrl.sv
module pes_seq_ctrl
  import pes_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  localparam int unsigned VLW  = $clog2(XLEN) + 1,
  localparam int unsigned IDXW = $clog2(XLEN)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [VLW-1:0]            vl,
  input  logic [XLEN-1:0]           pred,
  input  logic                      zero_mode,
  input  logic [NOPS-1:0][REGW-1:0] op_raw,
  input  remap_ent_t [NOPS-1:0]     op_ent,
  output logic                      busy,
  output logic                      done,
  output logic                      iss_valid,
  input  logic                      iss_ready,
  output issue_t                    iss
);
  logic                      run_q, done_q, zm_q;
  logic [XLEN-1:0]           pend_q, pred_q;
  logic [NOPS-1:0][REGW-1:0] base_q;
  logic [NOPS-1:0]           vec_q;

  logic [VLW-1:0]  vl_c;
  logic [XLEN-1:0] len_mask, init_mask, pick, pend_nx;
  logic [IDXW-1:0] idx;
  logic            any, fire;
  logic [NOPS-1:0][REGW-1:0] reg_out;

  assign vl_c = (vl > VLW'(XLEN)) ? VLW'(XLEN) : vl;

  always_comb begin
    for (int j = 0; j < XLEN; j++) len_mask[j] = (VLW'(j) < vl_c);
  end

  assign init_mask = (zero_mode ? '1 : pred) & len_mask;

  pes_first_set #(.W(XLEN)) u_pick (
    .vec(pend_q), .onehot(pick), .idx(idx), .any(any)
  );

  for (genvar k = 0; k < NOPS; k++) begin : g_step
    assign reg_out[k] = vec_q[k] ? base_q[k] + REGW'(idx) : base_q[k];
  end

  assign iss_valid = run_q;
  assign fire      = iss_valid & iss_ready;
  assign pend_nx   = pend_q & ~pick;
  assign iss.rd    = reg_out[0];
  assign iss.rs1   = reg_out[1];
  assign iss.rs2   = reg_out[2];
  assign iss.zero  = zm_q & ~|(pick & pred_q);
  assign busy      = run_q;
  assign done      = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      zm_q   <= 1'b0;
      pend_q <= '0;
      pred_q <= '0;
      base_q <= '0;
      vec_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!run_q) begin
        if (start) begin
          pend_q <= init_mask;
          pred_q <= pred;
          zm_q   <= zero_mode;
          for (int k = 0; k < NOPS; k++) begin
            base_q[k] <= op_ent[k].isvec ? op_ent[k].base : op_raw[k];
            vec_q[k]  <= op_ent[k].isvec;
          end
          if (init_mask == '0) done_q <= 1'b1;
          else                 run_q  <= 1'b1;
        end
      end else if (fire) begin
        pend_q <= pend_nx;
        if (pend_nx == '0) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && !iss_ready |=> iss_valid && $stable(iss));
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R2
  busy_work_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> any);
  // R3
  skip_pred_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && !zm_q |-> |(pick & pred_q));
  // R10
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(base_q) && $stable(zm_q) && $stable(pred_q));
endmodule

// File: rtl/pred_elem_seq.sv
module pred_elem_seq
  import pes_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  localparam int unsigned VLW  = $clog2(XLEN) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tbl_we,
  input  logic [REGW-1:0] tbl_addr,
  input  logic            tbl_isvec,
  input  logic [REGW-1:0] tbl_base,
  input  logic            start,
  input  logic [VLW-1:0]  vl,
  input  logic [XLEN-1:0] pred,
  input  logic            zero_mode,
  input  logic [REGW-1:0] op_rd,
  input  logic [REGW-1:0] op_rs1,
  input  logic [REGW-1:0] op_rs2,
  output logic            busy,
  output logic            done,
  output logic            iss_valid,
  input  logic            iss_ready,
  output logic [REGW-1:0] iss_rd,
  output logic [REGW-1:0] iss_rs1,
  output logic [REGW-1:0] iss_rs2,
  output logic            iss_zero
);
  logic [NOPS-1:0][REGW-1:0] op_raw;
  remap_ent_t [NOPS-1:0]     op_ent;
  remap_ent_t                wr_ent;
  issue_t                    iss;

  assign op_raw       = {op_rs2, op_rs1, op_rd};
  assign wr_ent.isvec = tbl_isvec;
  assign wr_ent.base  = tbl_base;

  pes_remap_table u_tbl (
    .clk(clk), .rst_n(rst_n), .we(tbl_we), .waddr(tbl_addr),
    .wdata(wr_ent), .raddr(op_raw), .rdata(op_ent)
  );

  pes_seq_ctrl #(.XLEN(XLEN)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .pred(pred),
    .zero_mode(zero_mode), .op_raw(op_raw), .op_ent(op_ent),
    .busy(busy), .done(done), .iss_valid(iss_valid),
    .iss_ready(iss_ready), .iss(iss)
  );

  assign iss_rd   = iss.rd;
  assign iss_rs1  = iss.rs1;
  assign iss_rs2  = iss.rs2;
  assign iss_zero = iss.zero;
endmodule

// File: tb/sim_pred_elem_seq.sv
`timescale 1ns/1ps
module sim_pred_elem_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tbl_we = 1'b0, tbl_isvec = 1'b0;
  logic [4:0]  tbl_addr = '0, tbl_base = '0;
  logic        start = 1'b0, zero_mode = 1'b0;
  logic [5:0]  vl = '0;
  logic [31:0] pred = '0;
  logic [4:0]  op_rd = '0, op_rs1 = '0, op_rs2 = '0;
  logic        busy, done, iss_valid, iss_zero;
  logic        iss_ready = 1'b1;
  logic [4:0]  iss_rd, iss_rs1, iss_rs2;

  always #2.5 clk = ~clk;

  pred_elem_seq u0 (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_isvec(tbl_isvec), .tbl_base(tbl_base), .start(start), .vl(vl),
    .pred(pred), .zero_mode(zero_mode), .op_rd(op_rd), .op_rs1(op_rs1),
    .op_rs2(op_rs2), .busy(busy), .done(done), .iss_valid(iss_valid),
    .iss_ready(iss_ready), .iss_rd(iss_rd), .iss_rs1(iss_rs1),
    .iss_rs2(iss_rs2), .iss_zero(iss_zero)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [15:0] expq[$];
  string       tagq[$];
  logic        m_vec [32];
  logic [4:0]  m_base [32];
  int          rmode = 0;
  logic [15:0] lfsr = 16'hACE1;
  realtime     last_fire_t = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [4:0] mapr(input logic [4:0] r, input int i);
    return m_vec[r] ? 5'(m_base[r] + 5'(i)) : r;
  endfunction

  // ready driver
  initial forever begin
    @(posedge clk); #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    iss_ready = (rmode == 0) ? 1'b1 : (rmode == 1) ? lfsr[0] : 1'b0;
  end

  // monitor / scoreboard
  logic        prev_hold = 0;
  logic [15:0] prev_tup = '0;
  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      if (prev_hold)
        chk(iss_valid && {iss_rd, iss_rs1, iss_rs2, iss_zero} == prev_tup, "R7",
            {15'd0, iss_valid, iss_rd, iss_rs1, iss_rs2, iss_zero}, {16'd1, prev_tup});
      if (iss_valid && iss_ready) begin
        if (expq.size() == 0)
          chk(0, "R10", {16'd0, iss_rd, iss_rs1, iss_rs2, iss_zero}, 32'hFFFFFFFF);
        else begin
          automatic logic [15:0] e = expq.pop_front();
          automatic string t = tagq.pop_front();
          chk({iss_rd, iss_rs1, iss_rs2, iss_zero} == e, t,
              {16'd0, iss_rd, iss_rs1, iss_rs2, iss_zero}, {16'd0, e});
        end
        last_fire_t = $realtime;
      end
      prev_hold = iss_valid && !iss_ready;
      prev_tup  = {iss_rd, iss_rs1, iss_rs2, iss_zero};
    end
  end

  task automatic wr_tbl(input logic [4:0] a, input logic v, input logic [4:0] b);
    @(posedge clk); #1;
    tbl_we = 1; tbl_addr = a; tbl_isvec = v; tbl_base = b;
    @(posedge clk); #1;
    tbl_we = 0;
    m_vec[a] = v; m_base[a] = b;
  endtask

  // returns 1 when the operation issues nothing
  task automatic launch(input logic [5:0] l, input logic [31:0] p, input logic zm,
                        input logic [4:0] d, input logic [4:0] s1, input logic [4:0] s2,
                        input string tag, output bit empty);
    int n = (l > 32) ? 32 : int'(l);
    empty = 1;
    for (int i = 0; i < n; i++) begin
      if (p[i] || zm) begin
        expq.push_back({mapr(d, i), mapr(s1, i), mapr(s2, i), ~p[i]});
        tagq.push_back(tag);
        empty = 0;
      end
    end
    @(posedge clk); #1;
    vl = l; pred = p; zero_mode = zm; op_rd = d; op_rs1 = s1; op_rs2 = s2; start = 1;
    @(posedge clk); #1;
    start = 0;
    if (empty) begin
      @(negedge clk);
      chk(done && !busy && !iss_valid, "R9", {29'd0, done, busy, iss_valid}, 32'h4);
      @(negedge clk);
      chk(!done, "R8", {31'd0, done}, 0);
    end
  endtask

  task automatic finish_op();
    bit seen = 0;
    for (int c = 0; c < 400 && !seen; c++) begin
      @(negedge clk);
      if (done) seen = 1;
    end
    chk(seen, "R8", {31'd0, seen}, 1);
    chk(($realtime - last_fire_t) == 5.0, "R8", 32'($realtime - last_fire_t), 5);
    chk(!busy, "R8", {31'd0, busy}, 0);
    chk(expq.size() == 0, "R2", expq.size(), 0);
    expq.delete(); tagq.delete();
    @(negedge clk);
    chk(!done, "R8", {31'd0, done}, 0);
  endtask

  task automatic run_op(input logic [5:0] l, input logic [31:0] p, input logic zm,
                        input logic [4:0] d, input logic [4:0] s1, input logic [4:0] s2,
                        input string tag);
    bit e;
    launch(l, p, zm, d, s1, s2, tag, e);
    if (!e) finish_op();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    for (int r = 0; r < 32; r++) begin m_vec[r] = 0; m_base[r] = 5'(r); end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !iss_valid, "R1", {29'd0, busy, done, iss_valid}, 0);
    // R1: all entries not-vector, so registers pass straight through
    run_op(6'd2, 32'h3, 0, 5'd7, 5'd8, 5'd9, "R1");

    wr_tbl(5'd1, 1, 5'd8);
    wr_tbl(5'd2, 1, 5'd16);
    wr_tbl(5'd3, 0, 5'd12);
    wr_tbl(5'd4, 1, 5'd30);

    rmode = 0;
    run_op(6'd8, 32'h0000_00A5, 0, 5'd1, 5'd2, 5'd3, "R3");
    rmode = 1;
    run_op(6'd6, 32'h0000_0005, 1, 5'd4, 5'd3, 5'd2, "R4");
    run_op(6'd32, 32'hFFFF_FFFF, 0, 5'd2, 5'd3, 5'd1, "R2");
    run_op(6'd40, 32'hFFFF_0000, 0, 5'd1, 5'd1, 5'd4, "R11");
    run_op(6'd5, 32'hFFFF_FFE0, 1, 5'd3, 5'd4, 5'd3, "R5");
    rmode = 0;
    run_op(6'd0, 32'hFFFF_FFFF, 1, 5'd1, 5'd2, 5'd3, "R9");
    run_op(6'd8, 32'h0000_FF00, 0, 5'd1, 5'd2, 5'd3, "R9");
    run_op(6'd3, 32'h0, 1, 5'd1, 5'd2, 5'd3, "R4");

    // R10 and R6: stall the stream, then disturb it while busy
    begin
      bit e;
      rmode = 2;
      launch(6'd4, 32'h0000_000F, 0, 5'd1, 5'd2, 5'd3, "R6", e);
      @(posedge clk); #1;
      vl = 6'd9; pred = 32'h1FF; op_rd = 5'd4; start = 1;
      @(posedge clk); #1;
      start = 0;
      tbl_we = 1; tbl_addr = 5'd1; tbl_isvec = 1; tbl_base = 5'd20;
      @(posedge clk); #1;
      tbl_we = 0;
      @(negedge clk);
      chk(busy, "R10", {31'd0, busy}, 1);
      rmode = 0;
      finish_op();
      repeat (3) @(negedge clk);
      chk(!iss_valid, "R10", {31'd0, iss_valid}, 0);
      m_vec[1] = 1; m_base[1] = 5'd20;
    end
    // R6: new entry now used
    run_op(6'd3, 32'h7, 0, 5'd1, 5'd1, 5'd3, "R6");

    repeat (2) @(negedge clk);
    summary();
  end
endmodule